// File: doc/BRIEF.md
# Program Exception Entry Controller

This block sits at the commit stage of a simple in-order 32-bit core. Every cycle it looks at the decode status of the oldest instruction and decides whether that instruction raises a program exception. The status it sees says whether the opcode is implemented, whether it is in the illegal class, whether it is privileged, whether it is a special- or device-register move that names an undefined or privileged register number, and whether a conditional trap has fired. When more than one program cause applies, the block picks a single winning cause.

On entry, and within one clock edge, it does all of the following:
- saves the faulting instruction's address and the state word as it was before entry;
- clears the mode and enable bits that a handler must start without;
- loads the syndrome register with one cause flag, plus a flag for the variable-length encoding;
- issues a redirect to a handler address, formed from the upper bits of a vector prefix and a fixed low offset.

The faulting instruction's write-back is suppressed in the same cycle. When no exception is taken, the surrounding core can write the state word through a simple write port.

Top module: `prog_exc_entry`

## Requirements
- R1: No exception is taken in a cycle where `commit_valid_i` is 0 or `higher_exc_i` is 1. In such a cycle `redirect_o` is 0, `cause_o` is 0, and the save and syndrome registers keep their values.
- R2: The illegal cause (`cause_o` = 1) is raised by any of these:
  - an unimplemented opcode;
  - an opcode from the illegal class;
  - a register move (`spr_move_i`) whose register number is undefined (`spr_undef_i`).
- R3: The privileged cause (`cause_o` = 2) is raised only while the user bit (state bit 14) is 1, by a privileged instruction or by a register move to a privileged register number. With bit 14 at 0 neither of these raises anything.
- R4: The trap cause (`cause_o` = 3) is raised only when `trap_insn_i` and `trap_cond_i` are both 1 and `trap_dbg_i` is 0.
- R5: Cause priority is illegal, then privileged, then trap. A move to an undefined register number in user mode is therefore illegal, not privileged.
- R6: On entry, save register 0 receives `insn_addr_i` and save register 1 receives the whole state word as it was before entry.
- R7: On entry, state bits 25, 18, 15, 14, 13, 11, 8, 5, 4 and 2 are cleared. All other bits, including the bits at positions 17, 12 and 9, keep their values.
- R8: On entry, the syndrome register receives exactly one cause flag: bit 27 for illegal, bit 26 for privileged, bit 25 for trap. Bit 5 is set when `insn_vle_i` is 1. Every other syndrome bit is 0.
- R9: `redirect_pc_o` is `prefix_i` with its low 8 bits replaced by 0x60.
- R10: The redirect, the cause report and all register updates happen in the cycle of the faulting commit. `wb_en_o` is 0 in that cycle, and equals `commit_valid_i & wb_req_i` otherwise.
- R11: Reset clears all four registers. Without an entry, `state_wr_i` loads `state_wdata_i` into the state word at the next edge, and an entry in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid_i | input | 1 | Oldest instruction commits this cycle |
| higher_exc_i | input | 1 | A higher-priority exception is pending for it |
| insn_addr_i | input | 32 | Effective address of the instruction |
| insn_vle_i | input | 1 | Instruction uses variable-length encoding |
| unimpl_i | input | 1 | Opcode not implemented |
| ill_class_i | input | 1 | Opcode in illegal class |
| priv_insn_i | input | 1 | Privileged instruction |
| spr_move_i | input | 1 | Special/device register move |
| spr_undef_i | input | 1 | Register number undefined |
| spr_priv_i | input | 1 | Register number in privileged range |
| trap_insn_i | input | 1 | Conditional trap instruction |
| trap_cond_i | input | 1 | Trap condition true |
| trap_dbg_i | input | 1 | Trap handled by debug instead |
| wb_req_i | input | 1 | Instruction wants to write back |
| state_wr_i | input | 1 | State word write strobe |
| state_wdata_i | input | 32 | State word write data |
| prefix_i | input | 32 | Vector prefix |
| redirect_o | output | 1 | Redirect pulse to handler |
| redirect_pc_o | output | 32 | Handler fetch address |
| cause_o | output | 2 | Winning cause: 0 none, 1 illegal, 2 privileged, 3 trap |
| wb_en_o | output | 1 | Write-back enable |
| save0_o | output | 32 | Save register 0 |
| save1_o | output | 32 | Save register 1 |
| state_o | output | 32 | State word |
| syndrome_o | output | 32 | Syndrome register |

## Verification
The cause selection is tried first with single causes, each alone, in both user and supervisor mode, which separates the user-mode gating from the raw decode terms. It is then tried with combined causes, including an undefined privileged register number in user mode, which shows the priority order. The trap is tried with its condition false and with debug handling on, to tell the trap gate from a plain decode flag. An all-ones state word shows which state bits are cleared and which are kept. Long random runs against a behavioural model then cover the interaction with blocking, write-back and the state write port.

// File: rtl/prog_exc_pkg.sv
package prog_exc_pkg;
   localparam int ST_W = 32;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_ILL  = 2'd1,
      CAUSE_PRIV = 2'd2,
      CAUSE_TRAP = 2'd3
   } cause_e;

   localparam int ST_SPV = 25;
   localparam int ST_WE  = 18;
   localparam int ST_CE  = 17;
   localparam int ST_EE  = 15;
   localparam int ST_PR  = 14;
   localparam int ST_FP  = 13;
   localparam int ST_ME  = 12;
   localparam int ST_FE0 = 11;
   localparam int ST_DE  = 9;
   localparam int ST_FE1 = 8;
   localparam int ST_IS  = 5;
   localparam int ST_DS  = 4;
   localparam int ST_PMM = 2;

   localparam int SY_ILL  = 27;
   localparam int SY_PRIV = 26;
   localparam int SY_TRAP = 25;
   localparam int SY_VLE  = 5;

   function automatic logic [ST_W-1:0] entry_clear_mask();
      logic [ST_W-1:0] m;
      m = '0;
      m[ST_SPV] = 1'b1; m[ST_WE]  = 1'b1; m[ST_EE]  = 1'b1;
      m[ST_PR]  = 1'b1; m[ST_FP]  = 1'b1; m[ST_FE0] = 1'b1;
      m[ST_FE1] = 1'b1; m[ST_IS]  = 1'b1; m[ST_DS]  = 1'b1;
      m[ST_PMM] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/prog_exc_classify.sv
module prog_exc_classify
   import prog_exc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   user_i,
   input  logic   unimpl_i,
   input  logic   ill_class_i,
   input  logic   priv_insn_i,
   input  logic   spr_move_i,
   input  logic   spr_undef_i,
   input  logic   spr_priv_i,
   input  logic   trap_insn_i,
   input  logic   trap_cond_i,
   input  logic   trap_dbg_i,
   output cause_e cause_o
);
   logic is_ill, is_priv, is_trap;

   assign is_ill  = unimpl_i | ill_class_i | (spr_move_i & spr_undef_i);
   assign is_priv = user_i & (priv_insn_i | (spr_move_i & spr_priv_i));
   assign is_trap = trap_insn_i & trap_cond_i & ~trap_dbg_i;

   always_comb begin
      if (is_ill)       cause_o = CAUSE_ILL;
      else if (is_priv) cause_o = CAUSE_PRIV;
      else if (is_trap) cause_o = CAUSE_TRAP;
      else              cause_o = CAUSE_NONE;
   end

   // R3: privileged cause only reported in user mode
   p_priv_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_o == CAUSE_PRIV) |-> user_i);
   // R5: an undefined register number always wins over privilege
   p_undef_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_move_i && spr_undef_i) |-> (cause_o == CAUSE_ILL));
   // R4: debug-handled trap never reported as program trap
   p_trap_dbg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_dbg_i |-> (cause_o != CAUSE_TRAP));
endmodule

// File: rtl/prog_exc_regs.sv
module prog_exc_regs
   import prog_exc_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              VEC_LO_W    = 8,
   parameter logic [7:0]      VEC_OFFSET  = 8'h60,
   parameter bit              HAS_VLE     = 1'b1,
   parameter logic [ST_W-1:0] RESET_STATE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_i,
   input  cause_e          cause_i,
   input  logic [XLEN-1:0] addr_i,
   input  logic            vle_i,
   input  logic [XLEN-1:0] prefix_i,
   input  logic            st_wr_i,
   input  logic [ST_W-1:0] st_wdata_i,
   output logic [XLEN-1:0] save0_o,
   output logic [ST_W-1:0] save1_o,
   output logic [ST_W-1:0] state_o,
   output logic [ST_W-1:0] syndrome_o,
   output logic [XLEN-1:0] vec_pc_o
);
   localparam logic [ST_W-1:0] CLR_MASK = entry_clear_mask();

   logic            vle_flag;
   logic [ST_W-1:0] syn_next;

   generate
      if (HAS_VLE) begin : g_vle
         assign vle_flag = vle_i;
      end else begin : g_no_vle
         assign vle_flag = 1'b0;
      end
   endgenerate

   always_comb begin
      syn_next = '0;
      unique case (cause_i)
         CAUSE_ILL:  syn_next[SY_ILL]  = 1'b1;
         CAUSE_PRIV: syn_next[SY_PRIV] = 1'b1;
         CAUSE_TRAP: syn_next[SY_TRAP] = 1'b1;
         default:    syn_next = '0;
      endcase
      syn_next[SY_VLE] = vle_flag;
   end

   assign vec_pc_o = {prefix_i[XLEN-1:VEC_LO_W], VEC_OFFSET[VEC_LO_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         save0_o    <= '0;
         save1_o    <= '0;
         state_o    <= RESET_STATE;
         syndrome_o <= '0;
      end else if (take_i) begin
         save0_o    <= addr_i;
         save1_o    <= state_o;
         state_o    <= state_o & ~CLR_MASK;
         syndrome_o <= syn_next;
      end else if (st_wr_i) begin
         state_o    <= st_wdata_i;
      end
   end

   // R6: save registers capture address and prior state word
   p_save0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (save0_o == $past(addr_i)));
   p_save1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (save1_o == $past(state_o)));
   // R7: user bit dropped, critical/machine-check/debug enables kept
   p_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (!state_o[ST_PR] && state_o[ST_CE] == $past(state_o[ST_CE])
                  && state_o[ST_ME] == $past(state_o[ST_ME])
                  && state_o[ST_DE] == $past(state_o[ST_DE])));
   // R8: at most one cause flag in the syndrome
   p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(syndrome_o[SY_ILL:SY_TRAP]));
   // R9: handler address low byte is the fixed offset
   p_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_pc_o[VEC_LO_W-1:0] == VEC_OFFSET[VEC_LO_W-1:0]);
   // R1: no entry leaves save and syndrome registers alone
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> ($stable(save0_o) && $stable(save1_o) && $stable(syndrome_o)));
endmodule

// File: rtl/prog_exc_entry.sv
module prog_exc_entry
   import prog_exc_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              VEC_LO_W    = 8,
   parameter logic [7:0]      VEC_OFFSET  = 8'h60,
   parameter bit              HAS_VLE     = 1'b1,
   parameter logic [ST_W-1:0] RESET_STATE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            commit_valid_i,
   input  logic            higher_exc_i,
   input  logic [XLEN-1:0] insn_addr_i,
   input  logic            insn_vle_i,
   input  logic            unimpl_i,
   input  logic            ill_class_i,
   input  logic            priv_insn_i,
   input  logic            spr_move_i,
   input  logic            spr_undef_i,
   input  logic            spr_priv_i,
   input  logic            trap_insn_i,
   input  logic            trap_cond_i,
   input  logic            trap_dbg_i,
   input  logic            wb_req_i,
   input  logic            state_wr_i,
   input  logic [ST_W-1:0] state_wdata_i,
   input  logic [XLEN-1:0] prefix_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] redirect_pc_o,
   output logic [1:0]      cause_o,
   output logic            wb_en_o,
   output logic [XLEN-1:0] save0_o,
   output logic [ST_W-1:0] save1_o,
   output logic [ST_W-1:0] state_o,
   output logic [ST_W-1:0] syndrome_o
);
   generate
      if (VEC_LO_W < 1 || VEC_LO_W > 8) begin : g_bad_lo
         $error("VEC_LO_W must lie in 1..8");
      end
      if (XLEN <= VEC_LO_W) begin : g_bad_xlen
         $error("XLEN must exceed VEC_LO_W");
      end
   endgenerate

   cause_e raw_cause;
   logic   eligible;
   logic   take;

   prog_exc_classify u_classify (
      .clk         (clk),
      .rst_n       (rst_n),
      .user_i      (state_o[ST_PR]),
      .unimpl_i    (unimpl_i),
      .ill_class_i (ill_class_i),
      .priv_insn_i (priv_insn_i),
      .spr_move_i  (spr_move_i),
      .spr_undef_i (spr_undef_i),
      .spr_priv_i  (spr_priv_i),
      .trap_insn_i (trap_insn_i),
      .trap_cond_i (trap_cond_i),
      .trap_dbg_i  (trap_dbg_i),
      .cause_o     (raw_cause)
   );

   assign eligible   = commit_valid_i & ~higher_exc_i;
   assign take       = eligible & (raw_cause != CAUSE_NONE);
   assign redirect_o = take;
   assign cause_o    = take ? raw_cause : CAUSE_NONE;
   assign wb_en_o    = commit_valid_i & wb_req_i & ~take;

   prog_exc_regs #(
      .XLEN        (XLEN),
      .VEC_LO_W    (VEC_LO_W),
      .VEC_OFFSET  (VEC_OFFSET),
      .HAS_VLE     (HAS_VLE),
      .RESET_STATE (RESET_STATE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .cause_i    (cause_e'(cause_o)),
      .addr_i     (insn_addr_i),
      .vle_i      (insn_vle_i),
      .prefix_i   (prefix_i),
      .st_wr_i    (state_wr_i),
      .st_wdata_i (state_wdata_i),
      .save0_o    (save0_o),
      .save1_o    (save1_o),
      .state_o    (state_o),
      .syndrome_o (syndrome_o),
      .vec_pc_o   (redirect_pc_o)
   );

   // R10: a faulting instruction never writes back
   p_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> !wb_en_o);
   // R1: pending higher exception or idle commit blocks entry
   p_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (higher_exc_i || !commit_valid_i) |-> (!redirect_o && cause_o == 2'd0));
endmodule

// File: tb/prog_exc_entry_tb_top.sv
module prog_exc_entry_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cv, hx, vle, unimpl, illc, priv, sprm, sprund, sprpriv;
   logic        trp, tcond, tdbg, wbreq, stwr;
   logic [31:0] addr, stwd, prefix;
   logic        redirect, wb_en;
   logic [31:0] rpc, s0, s1, st, syn;
   logic [1:0]  cause;

   int errors = 0;
   int checks = 0;

   logic [31:0] m_s0, m_s1, m_st, m_syn;

   localparam logic [31:0] KEEP = 32'hFDFB_16CB;

   always #5 clk = ~clk;

   prog_exc_entry dut_i (
      .clk(clk), .rst_n(rst_n), .commit_valid_i(cv), .higher_exc_i(hx),
      .insn_addr_i(addr), .insn_vle_i(vle), .unimpl_i(unimpl),
      .ill_class_i(illc), .priv_insn_i(priv), .spr_move_i(sprm),
      .spr_undef_i(sprund), .spr_priv_i(sprpriv), .trap_insn_i(trp),
      .trap_cond_i(tcond), .trap_dbg_i(tdbg), .wb_req_i(wbreq),
      .state_wr_i(stwr), .state_wdata_i(stwd), .prefix_i(prefix),
      .redirect_o(redirect), .redirect_pc_o(rpc), .cause_o(cause),
      .wb_en_o(wb_en), .save0_o(s0), .save1_o(s1), .state_o(st),
      .syndrome_o(syn)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_cause();
      if (!cv || hx) return 0;
      if (unimpl || illc || (sprm && sprund)) return 1;
      if (m_st[14] && (priv || (sprm && sprpriv))) return 2;
      if (trp && tcond && !tdbg) return 3;
      return 0;
   endfunction

   task automatic idle_inputs();
      cv = 0; hx = 0; vle = 0; unimpl = 0; illc = 0; priv = 0; sprm = 0;
      sprund = 0; sprpriv = 0; trp = 0; tcond = 0; tdbg = 0; wbreq = 0;
      stwr = 0; stwd = '0; addr = '0;
   endtask

   // inputs already driven after a negedge; compare, clock, compare again
   task automatic cycle(input string tag);
      int c;
      logic [31:0] syn_e;
      #2;
      c = exp_cause();
      chk(tag, "cause", {30'd0, cause}, c);
      chk(tag, "redirect", {31'd0, redirect}, (c != 0));
      chk("R9", "redirect_pc", rpc, {prefix[31:8], 8'h60});
      chk("R10", "wb_en", {31'd0, wb_en}, (cv && wbreq && c == 0));
      @(posedge clk);
      if (c != 0) begin
         syn_e = 32'd0;
         if (c == 1) syn_e[27] = 1'b1;
         if (c == 2) syn_e[26] = 1'b1;
         if (c == 3) syn_e[25] = 1'b1;
         if (vle) syn_e[5] = 1'b1;
         m_s0 = addr; m_s1 = m_st; m_st = m_st & KEEP; m_syn = syn_e;
      end else if (stwr) begin
         m_st = stwd;
      end
      #1;
      chk("R6", "save0", s0, m_s0);
      chk("R6", "save1", s1, m_s1);
      chk("R7", "state", st, m_st);
      chk("R8", "syndrome", syn, m_syn);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic write_state(input logic [31:0] v);
      stwr = 1; stwd = v;
      cycle("R11");
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      idle_inputs();
      prefix = 32'h8000_0000;
      rst_n = 0;
      m_s0 = 0; m_s1 = 0; m_st = 0; m_syn = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R11: reset values
      chk("R11", "reset state", st, 32'h0);
      chk("R11", "reset syndrome", syn, 32'h0);
      chk("R11", "reset save0", s0, 32'h0);

      write_state(32'hFFFF_FFFF);
      chk("R11", "state after write", st, 32'hFFFF_FFFF);

      // R2 + R8: unimplemented opcode with variable-length encoding
      cv = 1; unimpl = 1; vle = 1; addr = 32'h0000_1234; wbreq = 1;
      cycle("R2");
      chk("R8", "syndrome ill+vle", syn, 32'h0800_0020);
      chk("R7", "state cleared", st, 32'hFDFB_16CB);
      chk("R6", "save1 prior", s1, 32'hFFFF_FFFF);

      // R3: privileged instruction in supervisor mode is ignored
      cv = 1; priv = 1; addr = 32'h44; wbreq = 1;
      cycle("R3");
      chk("R3", "syndrome kept", syn, 32'h0800_0020);
      cv = 1; sprm = 1; sprpriv = 1; addr = 32'h48;
      cycle("R3");

      // R3 + R7: privileged in user mode, CE/ME/DE kept
      write_state(32'h0002_5200);
      cv = 1; priv = 1; addr = 32'h100;
      cycle("R3");
      chk("R3", "syndrome priv", syn, 32'h0400_0000);
      chk("R7", "enables kept", st, 32'h0002_1200);

      // R2/R5: undefined register number in user mode is illegal
      write_state(32'h0000_4000);
      cv = 1; sprm = 1; sprund = 1; sprpriv = 1; addr = 32'h200;
      cycle("R5");
      chk("R5", "syndrome undef", syn, 32'h0800_0000);

      // R2: illegal class
      cv = 1; illc = 1; addr = 32'h204;
      cycle("R2");

      // R4: trap gating
      cv = 1; trp = 1; tcond = 1; tdbg = 1; addr = 32'h300;
      cycle("R4");
      cv = 1; trp = 1; tcond = 0; addr = 32'h304;
      cycle("R4");
      cv = 1; trp = 1; tcond = 1; addr = 32'h308; vle = 1;
      cycle("R4");
      chk("R4", "syndrome trap", syn, 32'h0200_0020);

      // R5: all causes in user mode -> illegal; priv+trap -> priv
      write_state(32'h0000_4000);
      cv = 1; priv = 1; trp = 1; tcond = 1; illc = 1; addr = 32'h400;
      cycle("R5");
      write_state(32'h0000_4000);
      cv = 1; priv = 1; trp = 1; tcond = 1; addr = 32'h404;
      cycle("R5");
      chk("R5", "syndrome priv over trap", syn, 32'h0400_0000);

      // R1: blocked by higher exception and by no commit
      cv = 1; hx = 1; unimpl = 1; addr = 32'h500;
      cycle("R1");
      chk("R1", "save0 unchanged", s0, 32'h404);
      cv = 0; unimpl = 1; addr = 32'h504;
      cycle("R1");

      // R9: vector formation
      prefix = 32'hABCD_EF12;
      cv = 1; unimpl = 1; addr = 32'h600;
      cycle("R9");
      chk("R9", "vector", rpc, 32'hABCD_EF60);

      // R10: write-back with and without fault
      cv = 1; wbreq = 1; addr = 32'h700;
      cycle("R10");
      cv = 1; wbreq = 1; trp = 1; tcond = 1; addr = 32'h704;
      cycle("R10");

      // R11: entry beats a simultaneous state write
      write_state(32'h0000_4000);
      cv = 1; unimpl = 1; stwr = 1; stwd = 32'h1234_5678; addr = 32'h800;
      cycle("R11");
      chk("R11", "entry over write", st, 32'h0);

      // random mix against the model
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] r;
         r = $urandom;
         cv = r[0] | r[1]; hx = (r[4:2] == 3'd0); vle = r[5];
         unimpl = (r[8:6] == 3'd0); illc = (r[11:9] == 3'd0);
         priv = r[12]; sprm = r[13]; sprund = r[14] & r[15];
         sprpriv = r[16]; trp = r[17]; tcond = r[18]; tdbg = r[19] & r[20];
         wbreq = r[21]; stwr = (r[24:22] == 3'd0);
         stwd = $urandom; addr = $urandom; prefix = $urandom;
         cycle("R5");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule